// File: doc/BRIEF.md
# EEPROM Write-Completion Poller

This block is a bus master that loads one byte or a full page burst into a parallel, byte-alterable EEPROM-style slave over a simple synchronous read/write port. After the last byte it does not sit out the worst-case programming time. It waits a short settling delay and then reads the slave repeatedly, inferring from the data bits themselves when the internal programming cycle has ended.

Two completion methods are selectable per transaction. In the data-bit method, the last written address is read until its bit 7 matches bit 7 of the saved last byte, and one more read must then return the whole byte. In the toggle method, the page base address is read over and over until two back-to-back reads agree on bit 6. A single-cycle `done` pulse reports success. A single-cycle `err` pulse reports that polling ran past a cycle limit without completing. In both cases the engine goes back to idle.

The host pulses `start` with a mode, a base address and a byte count, and supplies each byte through an indexed source port that answers in the same cycle.

Top module: `eep_write_poller`

## Requirements
- R1: After reset, and at any time the engine is idle, `busy`, `done`, `err`, `mem_we` and `mem_re` are all low.
- R2: A transaction writes `count_m1`+1 bytes. Byte i goes to the address whose upper bits (above bit PAGE_W-1) equal those of `base_addr` and whose low PAGE_W bits are `base_addr` low bits plus i, modulo 2^PAGE_W. Byte i carries the `src_data` value presented while `src_idx` equals i.
- R3: Consecutive write strobes within a burst are exactly GAP_CYC+1 clock cycles apart.
- R4: The first poll read strobe comes exactly SETTLE_CYC+1 cycles after the last write strobe, and no read comes earlier.
- R5: With `mode_toggle`=0, every poll read targets the last written address. Once a read returns bit 7 equal to the saved byte's bit 7, the next read is a confirmation read. `done` follows only if that confirmation read returns the full saved byte; otherwise polling resumes.
- R6: With `mode_toggle`=1, every poll read targets `base_addr`. `done` follows the first read whose bit 6 equals bit 6 of the previous read, so at least two reads are made.
- R7: If polling has not completed after TIMEOUT_CYC cycles, `err` pulses for one cycle and no `done` is produced. The count starts from the cycle of the first read strobe, so `err` rises exactly TIMEOUT_CYC cycles after that strobe.
- R8: A `start` pulse while `busy` is high has no effect on the running transaction.
- R9: `done` and `err` are one-cycle pulses, never high together, and `busy` is low while either is high.
- R10: `mem_we` and `mem_re` are never high in the same cycle. Read data is taken from `mem_rdata` in the cycle after `mem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a transaction when idle |
| mode_toggle | input | 1 | 0 selects data-bit polling, 1 selects toggle polling |
| count_m1 | input | PAGE_W | Number of bytes minus one |
| base_addr | input | ADDR_W | Address of the first byte |
| src_idx | output | PAGE_W | Index of the byte wanted from the source |
| src_data | input | DATA_W | Source byte for `src_idx`, same cycle |
| mem_we | output | 1 | Write strobe to the slave |
| mem_re | output | 1 | Read strobe to the slave |
| mem_addr | output | ADDR_W | Slave address |
| mem_wdata | output | DATA_W | Slave write data |
| mem_rdata | input | DATA_W | Slave read data, valid the cycle after `mem_re` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Programming completed pulse |
| err | output | 1 | Polling timeout pulse |

## Verification
The hardest situation to reach is a data-bit poll where bit 7 already agrees but the confirmation read still disagrees. A real slave only produces this in the narrow moment when its cells settle. The bench slave model therefore injects a chosen number of readbacks with bit 7 intact and bit 0 flipped once programming has ended. The bench then checks that `done` arrives only after every corrupted readback has been consumed and that the final read equals the saved byte. Timeouts are reached by giving the model a programming time far beyond the limit in both modes.

// File: rtl/eep_poll_pkg.sv
`timescale 1ns/1ps
package eep_poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WRITE  = 3'd1,
        ST_GAP    = 3'd2,
        ST_SETTLE = 3'd3,
        ST_RD     = 3'd4,
        ST_WAIT   = 3'd5
    } poll_st_e;

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
endpackage

// File: rtl/eep_page_addr.sv
`timescale 1ns/1ps
module eep_page_addr #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 7
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PAGE_W-1:0] idx,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_W-1:0] low_sum;

    always_comb begin
        low_sum = base[PAGE_W-1:0] + idx;
        addr    = {base[ADDR_W-1:PAGE_W], low_sum};
    end
endmodule

// File: rtl/eep_poll_eval.sv
`timescale 1ns/1ps
module eep_poll_eval
    import eep_poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              toggle_mode,
    input  logic              confirm,
    input  logic              have_prev,
    input  logic              prev_tog,
    input  logic [DATA_W-1:0] saved,
    input  logic [DATA_W-1:0] rdata,
    output logic              finish,
    output logic              confirm_nx,
    output logic              have_prev_nx,
    output logic              prev_tog_nx
);
    always_comb begin
        finish       = 1'b0;
        confirm_nx   = 1'b0;
        have_prev_nx = have_prev;
        prev_tog_nx  = prev_tog;
        if (toggle_mode) begin
            finish       = have_prev && (rdata[TOG_BIT] == prev_tog);
            have_prev_nx = 1'b1;
            prev_tog_nx  = rdata[TOG_BIT];
        end else if (!confirm) begin
            confirm_nx = (rdata[POLL_BIT] == saved[POLL_BIT]);
        end else begin
            finish = (rdata == saved);
        end
    end
endmodule

// File: rtl/eep_write_poller.sv
`timescale 1ns/1ps
module eep_write_poller
    import eep_poll_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 7,
    parameter int GAP_CYC     = 200,
    parameter int SETTLE_CYC  = 2000,
    parameter int TIMEOUT_CYC = 1100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_toggle,
    input  logic [PAGE_W-1:0] count_m1,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [PAGE_W-1:0] src_idx,
    input  logic [DATA_W-1:0] src_data,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int WAIT_MAX = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
    localparam int TMR_W    = $clog2(WAIT_MAX + 1);
    localparam int TOUT_W   = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        poll_st_e          st;
        logic              mode;
        logic [PAGE_W-1:0] cnt;
        logic [ADDR_W-1:0] base;
        logic [PAGE_W-1:0] idx;
        logic [TMR_W-1:0]  tmr;
        logic [TOUT_W-1:0] tout;
        logic [ADDR_W-1:0] last_addr;
        logic [DATA_W-1:0] last_data;
        logic              confirm;
        logic              have_prev;
        logic              prev_tog;
        logic              done;
        logic              err;
    } poll_reg_t;

    poll_reg_t r_q, r_d;

    logic [ADDR_W-1:0] wr_addr;
    logic              ev_finish, ev_confirm, ev_have_prev, ev_prev_tog;
    logic              tout_hit;

    eep_page_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .base (r_q.base),
        .idx  (r_q.idx),
        .addr (wr_addr)
    );

    eep_poll_eval #(.DATA_W(DATA_W)) u_eval (
        .toggle_mode  (r_q.mode),
        .confirm      (r_q.confirm),
        .have_prev    (r_q.have_prev),
        .prev_tog     (r_q.prev_tog),
        .saved        (r_q.last_data),
        .rdata        (mem_rdata),
        .finish       (ev_finish),
        .confirm_nx   (ev_confirm),
        .have_prev_nx (ev_have_prev),
        .prev_tog_nx  (ev_prev_tog)
    );

    assign tout_hit = (r_q.tout == TOUT_W'(TIMEOUT_CYC - 1));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st        = ST_WRITE;
                    r_d.mode      = mode_toggle;
                    r_d.cnt       = count_m1;
                    r_d.base      = base_addr;
                    r_d.idx       = '0;
                    r_d.confirm   = 1'b0;
                    r_d.have_prev = 1'b0;
                end
            end
            ST_WRITE: begin
                r_d.last_addr = wr_addr;
                r_d.last_data = src_data;
                r_d.tmr       = '0;
                if (r_q.idx == r_q.cnt) begin
                    r_d.st = ST_SETTLE;
                end else begin
                    r_d.idx = r_q.idx + PAGE_W'(1);
                    r_d.st  = ST_GAP;
                end
            end
            ST_GAP: begin
                r_d.tmr = r_q.tmr + TMR_W'(1);
                if (r_q.tmr == TMR_W'(GAP_CYC - 1)) r_d.st = ST_WRITE;
            end
            ST_SETTLE: begin
                r_d.tmr = r_q.tmr + TMR_W'(1);
                if (r_q.tmr == TMR_W'(SETTLE_CYC - 1)) begin
                    r_d.st   = ST_RD;
                    r_d.tout = '0;
                end
            end
            ST_RD: begin
                r_d.tout = r_q.tout + TOUT_W'(1);
                r_d.st   = ST_WAIT;
                if (tout_hit) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
            ST_WAIT: begin
                r_d.tout      = r_q.tout + TOUT_W'(1);
                r_d.confirm   = ev_confirm;
                r_d.have_prev = ev_have_prev;
                r_d.prev_tog  = ev_prev_tog;
                if (ev_finish) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (tout_hit) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end else begin
                    r_d.st = ST_RD;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        src_idx   = r_q.idx;
        mem_we    = (r_q.st == ST_WRITE);
        mem_re    = (r_q.st == ST_RD);
        mem_wdata = mem_we ? src_data : '0;
        if (mem_we)       mem_addr = wr_addr;
        else if (r_q.mode) mem_addr = r_q.base;
        else              mem_addr = r_q.last_addr;
        busy = (r_q.st != ST_IDLE);
        done = r_q.done;
        err  = r_q.err;
    end
endmodule

// File: rtl/eep_write_poller_chk.sv
`timescale 1ns/1ps
module eep_write_poller_chk #(
    parameter int GAP_CYC    = 200,
    parameter int SETTLE_CYC = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic mem_we,
    input logic mem_re,
    input logic busy,
    input logic done,
    input logic err
);
    localparam int SAT = ((GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC) + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] since_we_q;
    logic          wr_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_we_q <= CW'(SAT);
            wr_seen_q  <= 1'b0;
        end else begin
            if (mem_we)                   since_we_q <= '0;
            else if (since_we_q < CW'(SAT)) since_we_q <= since_we_q + CW'(1);
            if (!busy)       wr_seen_q <= 1'b0;
            else if (mem_we) wr_seen_q <= 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    assert_byte_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wr_seen_q) |-> (since_we_q == CW'(GAP_CYC)));

    assert_settle_before_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (since_we_q >= CW'(SETTLE_CYC)));

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_idle_on_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);

    assert_rw_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

bind eep_write_poller eep_write_poller_chk #(
    .GAP_CYC    (GAP_CYC),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_we (mem_we),
    .mem_re (mem_re),
    .busy   (busy),
    .done   (done),
    .err    (err)
);

// File: tb/eep_write_poller_tb.sv
`timescale 1ns/1ps
module eep_write_poller_tb;
    localparam int AW = 16, DW = 8, PW = 7;
    localparam int GAP = 3, SETTLE = 5, TOUT = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode_toggle = 1'b0;
    logic [PW-1:0] count_m1 = '0;
    logic [AW-1:0] base_addr = '0;
    logic [PW-1:0] src_idx;
    logic [DW-1:0] src_data;
    logic          mem_we, mem_re;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, err;

    always #2.5 clk = ~clk;

    eep_write_poller #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .GAP_CYC(GAP),
                       .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_toggle(mode_toggle),
        .count_m1(count_m1), .base_addr(base_addr), .src_idx(src_idx),
        .src_data(src_data), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err));

    int n_chk = 0, n_fail = 0;
    logic [7:0] seed_q = 8'h00;

    function automatic logic [7:0] pat(input logic [PW-1:0] i, input logic [7:0] s);
        return s + 8'(i) * 8'd29;
    endfunction

    always_comb src_data = pat(src_idx, seed_q);

    // slave model
    logic [7:0] arr [0:255];
    logic [7:0] pend [0:255];
    logic       pmask [0:255];
    logic [AW-1:0] wlog_a [0:255];
    logic [7:0]    wlog_d [0:255];
    logic [7:0] last_wr = 8'h00, last_rd_val = 8'h00;
    logic       tog = 1'b0;
    logic [AW-1:0] exp_rd_addr = '0;
    int cyc = 0, prog_time = 1, prog_left = 0, corrupt_left = 0;
    int wr_n = 0, rd_n = 0, rd_bad = 0, spacing_bad = 0, last_wr_cyc = 0;
    int first_rd_cyc = 0, first_gap = 0, done_n = 0, err_n = 0, err_cyc = 0, done_wide = 0;
    logic prev_done = 1'b0;

    initial for (int i = 0; i < 256; i++) begin arr[i] = 8'(i); pmask[i] = 1'b0; pend[i] = 8'h00; end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_we) begin
            pend[mem_addr[7:0]] = mem_wdata;
            pmask[mem_addr[7:0]] = 1'b1;
            last_wr = mem_wdata;
            prog_left = prog_time;
            if (wr_n > 0 && (cyc - last_wr_cyc) != GAP + 1) spacing_bad++;
            last_wr_cyc = cyc;
            wlog_a[wr_n[7:0]] = mem_addr;
            wlog_d[wr_n[7:0]] = mem_wdata;
            if (wr_n < 255) wr_n++;
        end else if (prog_left > 0) begin
            prog_left--;
            if (prog_left == 0)
                for (int i = 0; i < 256; i++)
                    if (pmask[i]) begin arr[i] = pend[i]; pmask[i] = 1'b0; end
        end
        if (mem_re) begin
            if (rd_n == 0) begin first_rd_cyc = cyc; first_gap = cyc - last_wr_cyc; end
            rd_n++;
            if (mem_addr != exp_rd_addr) rd_bad++;
            if (prog_left > 0) begin
                last_rd_val = {~last_wr[7], tog, last_wr[5:0]};
                tog = ~tog;
            end else if (corrupt_left > 0) begin
                last_rd_val = arr[mem_addr[7:0]] ^ 8'h01;
                corrupt_left--;
            end else begin
                last_rd_val = arr[mem_addr[7:0]];
            end
            mem_rdata <= last_rd_val;
        end
        if (done) begin done_n++; if (prev_done) done_wide++; end
        if (err) begin err_n++; err_cyc = cyc; end
        prev_done = done;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input bit md, input logic [AW-1:0] base, input logic [PW-1:0] cm1,
                       input int prog, input int corr, input bit exp_err, input bit poke);
        int k;
        int bad;
        logic [PW-1:0] lo;
        logic [AW-1:0] ea;
        @(negedge clk);
        wr_n = 0; rd_n = 0; rd_bad = 0; spacing_bad = 0; done_n = 0; err_n = 0; done_wide = 0;
        prog_time = prog; corrupt_left = corr;
        seed_q = 8'($urandom);
        lo = base[PW-1:0] + cm1;
        exp_rd_addr = md ? base : {base[AW-1:PW], lo};
        mode_toggle = md; base_addr = base; count_m1 = cm1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; count_m1 = cm1 + 7'd9; mode_toggle = ~md;
            @(negedge clk);
            start = 1'b0; count_m1 = cm1; mode_toggle = md;
        end
        k = 0;
        while (done_n == 0 && err_n == 0 && k < 20000) begin @(negedge clk); k++; end
        chk(k < 20000, "R7 completion or error reported", k, 20000);
        repeat (3) @(negedge clk);
        chk(wr_n == int'(cm1) + 1, "R2 write count", wr_n, int'(cm1) + 1);
        if (poke) chk(wr_n == int'(cm1) + 1, "R8 start while busy ignored", wr_n, int'(cm1) + 1);
        bad = 0;
        for (int i = 0; i <= int'(cm1); i++) begin
            lo = base[PW-1:0] + PW'(i);
            ea = {base[AW-1:PW], lo};
            if (wlog_a[i] != ea || wlog_d[i] != pat(PW'(i), seed_q)) bad++;
        end
        chk(bad == 0, "R2 write address/data", bad, 0);
        chk(spacing_bad == 0, "R3 write spacing", spacing_bad, 0);
        chk(first_gap == SETTLE + 1, "R4 settle before first read", first_gap, SETTLE + 1);
        chk(rd_bad == 0, md ? "R6 toggle read address" : "R5 poll read address", rd_bad, 0);
        if (exp_err) begin
            chk(err_n == 1 && done_n == 0, "R7 timeout flags err only", err_n * 10 + done_n, 10);
            chk(err_cyc - first_rd_cyc == TOUT, "R7 timeout cycle", err_cyc - first_rd_cyc, TOUT);
        end else begin
            chk(done_n == 1 && err_n == 0, "R9 single done", done_n * 10 + err_n, 10);
            chk(done_wide == 0, "R9 done width", done_wide, 0);
            if (md) begin
                chk(rd_n >= 2, "R6 at least two reads", rd_n, 2);
            end else begin
                chk(corrupt_left == 0, "R5 confirm read rejects mismatch", corrupt_left, 0);
                chk(last_rd_val == pat(cm1, seed_q), "R5 final read equals saved byte",
                    last_rd_val, pat(cm1, seed_q));
            end
            bad = 0;
            for (int i = 0; i <= int'(cm1); i++) begin
                lo = base[PW-1:0] + PW'(i);
                if (arr[{base[7], lo}] != pat(PW'(i), seed_q)) bad++;
            end
            chk(bad == 0, "R2 bytes committed", bad, 0);
        end
        chk(!busy && !mem_we && !mem_re, "R1 quiet after transaction", busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (4) @(negedge clk);
        chk(!busy && !done && !err && !mem_we && !mem_re, "R1 reset state",
            {busy, done, err, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_we && !mem_re, "R1 idle after reset", {busy, mem_we, mem_re}, 0);
        run(1'b0, 16'h1234, 7'd0,   20,     0, 1'b0, 1'b0); // R5 single byte
        run(1'b0, 16'hA3D0, 7'd127, 40,     0, 1'b0, 1'b0); // R2 full page, wraps
        run(1'b1, 16'h0F05, 7'd4,   60,     0, 1'b0, 1'b0); // R6 toggle
        run(1'b1, 16'h0F06, 7'd0,   1,      0, 1'b0, 1'b0); // R6 ready at first read
        run(1'b0, 16'h4242, 7'd3,   30,     2, 1'b0, 1'b0); // R5 corrupt confirm
        run(1'b0, 16'h0001, 7'd1,   100000, 0, 1'b1, 1'b0); // R7 data mode
        run(1'b1, 16'h0080, 7'd2,   100000, 0, 1'b1, 1'b0); // R7 toggle mode
        run(1'b0, 16'h7700, 7'd10,  25,     0, 1'b0, 1'b1); // R8 poke
        for (int t = 0; t < 16; t++) begin
            bit md;
            md = 1'($urandom);
            run(md, 16'($urandom), 7'($urandom), 1 + int'($urandom % 150),
                md ? 0 : int'($urandom % 3), 1'b0, 1'($urandom % 4 == 0));
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule